// File: doc/BRIEF.md
# Configurable LUT Logic Cell

This block is one programmable logic cell meant to be repeated across a gate-array fabric. It has four logic inputs and a carry input, and it drives a cell output and a carry output. The cell holds a small configuration word. That word sets the lookup-table contents, picks between plain logic and arithmetic operation, and chooses whether the cell output comes from a flip-flop or straight from the logic.

The lookup table is split into two halves, each addressed by the low three logic inputs. In logic mode the fourth input picks one half, so the pair acts as a single 4-input table. In arithmetic mode the two half outputs become the operands of a one-bit full adder. The adder's third input is the carry input, and its carry result leaves through the carry output toward the next cell.

Configuration is loaded serially, one bit per clock while the shift enable is high. The bit leaving the far end of the chain is presented on a pin, so several cells can be daisy-chained.

Top module: `lut_logic_cell`

## Requirements
- R1: Each rising clock edge with `cfg_en` high shifts `cfg_in` into the configuration chain. After 18 such shifts, the bit shifted first lands at configuration index 0 and the bit shifted last lands at index 17.
- R2: While `cfg_en` is low the configuration does not change, whatever `cfg_in` does. `cfg_out` stays constant and the cell function is unchanged.
- R3: With the mode bit (index 16) at 0, the logic result is configuration bit `{lin[3], lin[2], lin[1], lin[0]}`. Bits 0..7 form the lower half and bits 8..15 the upper half, both addressed by `lin[2:0]`, and `lin[3]`=1 selects the upper half.
- R4: With the mode bit at 1, the result is `lo ^ hi ^ cin` and `cout` is the majority of `lo`, `hi` and `cin`. Here `lo` is bit `lin[2:0]` and `hi` is bit `8+lin[2:0]` of the configuration. `lin[3]` is ignored.
- R5: With the mode bit at 0, `cout` is 0.
- R6: With the output-select bit (index 17) at 0, `cell_out` equals the current result combinationally, in the same cycle.
- R7: With the output-select bit at 1, `cell_out` shows the result captured at the most recent rising clock edge.
- R8: A rising edge with `rst_n` low clears the output flip-flop to 0. In registered mode this shows on `cell_out` after that edge.
- R9: Reset does not alter the configuration. After reset the cell computes the same function, and `cfg_out` holds its value.
- R10: `cfg_out` presents configuration index 0, so while shifting it emits the previously loaded word with bit 0 first. This lets cells be chained.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flip-flop and the configuration chain |
| rst_n | input | 1 | Synchronous active-low reset of the output flip-flop only |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out (chain end, index 0) |
| lin | input | HALF_IN+1 (4) | Logic inputs; low bits address the tables, top bit merges halves |
| cin | input | 1 | Carry input from the previous cell |
| cell_out | output | 1 | Cell result, registered or combinational |
| cout | output | 1 | Carry output to the next cell |

## Verification
The bench builds the cell with its default half-table address width of 3. This gives an 18-bit configuration word and 32 combinations of logic inputs and carry input, which is small enough to sweep every combination for each configuration. For each of several random table contents, the sweep covers both modes and both output selections, and it compares `cell_out` and `cout` against a model written from the requirements. Directed scenarios cover shifting a word through the chain, holding the chain with the enable low, and resetting the flip-flop without disturbing the configuration.

// File: rtl/lc_pkg.sv
// Package: shared encodings for the configurable logic cell.
// Assumes: a single configuration bit per mode choice.
package lc_pkg;

    // Operating mode of the cell, stored in one configuration bit.
    typedef enum logic {
        MODE_LOGIC = 1'b0,
        MODE_ARITH = 1'b1
    } cell_mode_e;

    // Output source of the cell, stored in one configuration bit.
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_sel_e;

    // Result of a one-bit addition.
    typedef struct packed {
        logic carry;
        logic sum;
    } add_res_t;

endpackage

// File: rtl/lc_cfg_chain.sv
// Module: serial configuration shift chain.
// New bits enter at the top index and move toward index 0, so the first bit
// shifted ends at index 0 after CFG_W shifts. Index 0 is driven out for chaining.
// Assumes: the chain holds its value across reset (no reset input here).
module lc_cfg_chain #(
    parameter int CFG_W = 18
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             shift_in,
    output logic [CFG_W-1:0] cfg_q,
    output logic             shift_out
);

    logic [CFG_W-1:0] chain_r;

    // Shift one bit per enabled clock, toward index 0.
    always_ff @(posedge clk) begin
        if (shift_en) begin
            chain_r <= {shift_in, chain_r[CFG_W-1:1]};
        end
    end

    assign cfg_q     = chain_r;
    assign shift_out = chain_r[0];

endmodule

// File: rtl/lc_lut_pair.sv
// Module: two half lookup tables sharing one address, plus the merge mux.
// Assumes: the table vector holds the lower half in its low HALF_BITS bits.
module lc_lut_pair #(
    parameter int HALF_IN = 3
) (
    input  logic [2*(1<<HALF_IN)-1:0] tbl_bits,
    input  logic [HALF_IN-1:0]        addr,
    input  logic                      merge_sel,
    output logic                      half_lo,
    output logic                      half_hi,
    output logic                      merged
);

    localparam int HALF_BITS = 1 << HALF_IN;

    logic [1:0] half_val;

    // One table half per generate iteration: 0 is lower, 1 is upper.
    for (genvar g = 0; g < 2; g++) begin : g_half
        logic [HALF_BITS-1:0] bits;
        assign bits        = tbl_bits[g*HALF_BITS +: HALF_BITS];
        assign half_val[g] = bits[addr];
    end

    assign half_lo = half_val[0];
    assign half_hi = half_val[1];

    // Merge mux: the top input picks which half answers.
    always_comb begin
        merged = merge_sel ? half_val[1] : half_val[0];
    end

endmodule

// File: rtl/lc_arith.sv
// Module: one-bit full adder and the mode mux.
// In arithmetic mode the sum is the result and the carry is driven out;
// in logic mode the merged table bit is the result and the carry is 0.
module lc_arith
    import lc_pkg::*;
(
    input  cell_mode_e mode,
    input  logic       op_a,
    input  logic       op_b,
    input  logic       carry_in,
    input  logic       merged,
    output logic       mode_res,
    output logic       carry_out
);

    add_res_t add_r;

    // Full adder on the two half outputs and the incoming carry.
    always_comb begin
        add_r.sum   = op_a ^ op_b ^ carry_in;
        add_r.carry = (op_a & op_b) | (carry_in & (op_a ^ op_b));
    end

    // Mode mux: pick the result and gate the carry output.
    always_comb begin
        if (mode == MODE_ARITH) begin
            mode_res  = add_r.sum;
            carry_out = add_r.carry;
        end else begin
            mode_res  = merged;
            carry_out = 1'b0;
        end
    end

endmodule

// File: rtl/lc_out_stage.sv
// Module: output flip-flop and the registered/combinational output mux.
// Assumes: reset is synchronous and active low and touches only this flop.
module lc_out_stage
    import lc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     d,
    input  out_sel_e out_sel,
    output logic     ff_q,
    output logic     cell_out
);

    // Capture the result each rising edge; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_q <= 1'b0;
        end else begin
            ff_q <= d;
        end
    end

    // Output mux: flop value or the live result.
    always_comb begin
        cell_out = (out_sel == OUT_REG) ? ff_q : d;
    end

endmodule

// File: rtl/lut_logic_cell.sv
// Module: top of the configurable logic cell.
// Configuration layout (index): table bits [2*HALF_BITS-1:0], mode bit next,
// output-select bit last. The low HALF_IN inputs address both table halves,
// and the top input merges them in logic mode.
// Assumes: configuration is loaded before the outputs are relied on.
module lut_logic_cell
    import lc_pkg::*;
#(
    parameter int HALF_IN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_in,
    output logic             cfg_out,
    input  logic [HALF_IN:0] lin,
    input  logic             cin,
    output logic             cell_out,
    output logic             cout
);

    localparam int HALF_BITS  = 1 << HALF_IN;
    localparam int TBL_BITS   = 2 * HALF_BITS;
    localparam int MODE_IDX   = TBL_BITS;
    localparam int OSEL_IDX   = TBL_BITS + 1;
    localparam int CFG_W      = TBL_BITS + 2;

    logic [CFG_W-1:0] cfg_q;
    cell_mode_e       cfg_mode;
    out_sel_e         cfg_osel;
    logic             half_lo;
    logic             half_hi;
    logic             merged;
    logic             mode_res;
    logic             ff_q;

    lc_cfg_chain #(
        .CFG_W(CFG_W)
    ) u_chain (
        .clk       (clk),
        .shift_en  (cfg_en),
        .shift_in  (cfg_in),
        .cfg_q     (cfg_q),
        .shift_out (cfg_out)
    );

    // Decode the two control bits into their enum types.
    always_comb begin
        cfg_mode = cell_mode_e'(cfg_q[MODE_IDX]);
        cfg_osel = out_sel_e'(cfg_q[OSEL_IDX]);
    end

    lc_lut_pair #(
        .HALF_IN(HALF_IN)
    ) u_luts (
        .tbl_bits  (cfg_q[TBL_BITS-1:0]),
        .addr      (lin[HALF_IN-1:0]),
        .merge_sel (lin[HALF_IN]),
        .half_lo   (half_lo),
        .half_hi   (half_hi),
        .merged    (merged)
    );

    lc_arith u_arith (
        .mode      (cfg_mode),
        .op_a      (half_lo),
        .op_b      (half_hi),
        .carry_in  (cin),
        .merged    (merged),
        .mode_res  (mode_res),
        .carry_out (cout)
    );

    lc_out_stage u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .d        (mode_res),
        .out_sel  (cfg_osel),
        .ff_q     (ff_q),
        .cell_out (cell_out)
    );

endmodule

// File: rtl/lc_cell_chk.sv
// Module: property checker for the logic cell, bound into the top.
module lc_cell_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_en,
    input logic cfg_out,
    input logic mode_bit,
    input logic osel_bit,
    input logic half_lo,
    input logic half_hi,
    input logic cin,
    input logic mode_res,
    input logic ff_q,
    input logic cell_out,
    input logic cout
);

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_out));

    // R4
    arith_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_bit |-> ({cout, mode_res} == ({1'b0, half_lo} + {1'b0, half_hi} + {1'b0, cin})));

    // R5
    logic_cout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_bit |-> (cout == 1'b0));

    // R6
    comb_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !osel_bit |-> (cell_out == mode_res));

    // R7
    reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (ff_q == $past(mode_res)));

    // R7
    reg_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osel_bit |-> (cell_out == ff_q));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ff_q == 1'b0));

endmodule

bind lut_logic_cell lc_cell_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_out  (cfg_out),
    .mode_bit (cfg_q[MODE_IDX]),
    .osel_bit (cfg_q[OSEL_IDX]),
    .half_lo  (half_lo),
    .half_hi  (half_hi),
    .cin      (cin),
    .mode_res (mode_res),
    .ff_q     (ff_q),
    .cell_out (cell_out),
    .cout     (cout)
);

// File: tb/sim_lut_logic_cell.sv
`timescale 1ns/1ps
// Directed bench for the logic cell, default parameters (18-bit configuration).
module sim_lut_logic_cell;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_in = 1'b0;
    logic       cfg_out;
    logic [3:0] lin = 4'd0;
    logic       cin = 1'b0;
    logic       cell_out;
    logic       cout;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    lut_logic_cell u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_in   (cfg_in),
        .cfg_out  (cfg_out),
        .lin      (lin),
        .cin      (cin),
        .cell_out (cell_out),
        .cout     (cout)
    );

    // Reference model from R3/R4/R5: returns {cout, result}.
    function automatic logic [1:0] model(input logic [17:0] c, input logic [3:0] x, input logic ci);
        logic lo, hi;
        lo = c[x[2:0]];
        hi = c[8 + x[2:0]];
        if (c[16]) return {(lo & hi) | (ci & (lo ^ hi)), lo ^ hi ^ ci};
        return {1'b0, x[3] ? hi : lo};
    endfunction

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // R1: shift a word in, bit 0 first.
    task automatic load_cfg(input logic [17:0] c);
        for (int k = 0; k < 18; k++) begin
            @(negedge clk);
            cfg_en = 1'b1;
            cfg_in = c[k];
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    // R3-style sweep: all 32 input/carry combinations against the model.
    task automatic sweep(input logic [17:0] c);
        logic [1:0] exp;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            lin = i[3:0];
            cin = i[4];
            exp = model(c, i[3:0], i[4]);
            if (c[17]) @(posedge clk);
            #1;
            if (c[16]) chk("R4 result", cell_out, exp[0]);
            else       chk("R3 result", cell_out, exp[0]);
            if (c[16]) chk("R4 carry", cout, exp[1]);
            else       chk("R5 carry", cout, exp[1]);
            if (c[17]) chk("R7 registered", cell_out, exp[0]);
            else       chk("R6 combinational", cell_out, exp[0]);
        end
    endtask

    task automatic t_reset_state();
        load_cfg(18'h2_FFFF);
        @(negedge clk);
        lin = 4'd0;
        @(posedge clk);
        #1;
        chk("R8 reset state", cell_out, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_modes();
        logic [15:0] tb;
        for (int b = 0; b < 3; b++) begin
            tb = 16'($urandom());
            for (int m = 0; m < 4; m++) begin
                load_cfg({m[1], m[0], tb});
                sweep({m[1], m[0], tb});
            end
        end
        load_cfg({2'b01, 16'hFF00});
        sweep({2'b01, 16'hFF00});
    endtask

    task automatic t_chain();
        logic [17:0] p, q;
        p = 18'h2_5A3C;
        q = 18'h1_C3A5;
        load_cfg(p);
        for (int k = 0; k < 18; k++) begin
            @(negedge clk);
            chk("R10 chain out", cfg_out, p[k]);
            cfg_en = 1'b1;
            cfg_in = q[k];
        end
        @(negedge clk);
        cfg_en = 1'b0;
        sweep(q);
    endtask

    task automatic t_hold();
        logic [17:0] c;
        c = 18'h0_6E91;
        load_cfg(c);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            cfg_in = ~cfg_in;
            chk("R2 hold", cfg_out, c[0]);
        end
        sweep(c);
    endtask

    task automatic t_reset_keep();
        logic [17:0] c;
        c = 18'h2_FFFF;
        load_cfg(c);
        @(negedge clk);
        lin = 4'd3;
        @(posedge clk);
        #1;
        chk("R7 registered one", cell_out, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R8 reset clears", cell_out, 1'b0);
        chk("R9 cfg_out kept", cfg_out, c[0]);
        @(negedge clk);
        rst_n = 1'b1;
        sweep(c);
    endtask

    initial begin
        t_reset_state();
        t_modes();
        t_chain();
        t_hold();
        t_reset_keep();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule